// File: doc/BRIEF.md
# Semaphore Release Writer

This block sits beside a command register file and watches writes to a group of four 32-bit semaphore registers: the upper half of a target address, the lower half, a payload word, and a packed control word. Writing the control word starts an operation. A release stores the payload to memory. A counter operation whose counter type is zero stores the value zero. Every other operation or counter type is rejected: a one-cycle unsupported pulse is raised and nothing reaches memory.

The result goes to the 64-bit address `{high, low}`. It takes one of two shapes, chosen by one bit of the control word. The short shape is a single 32-bit word. The long shape is a 16-byte record: a 64-bit value at the lower eight bytes and a 64-bit timestamp at the upper eight. The timestamp converts a free-running nanosecond count, sampled when the control word is written, into ticks at a ratio of 384/625. The conversion is split into a quotient part and a remainder part so that no intermediate product overflows. The divide by 625 runs on a one-bit-per-cycle sequential divider. `busy` stays high from the trigger until the memory write handshake completes, and control words written while busy are dropped.

Top module: `sem_release_writer`

## Requirements
- R1: After reset, `busy`, `unsupported` and `mem_valid` are all low.
- R2: Register writes land only at indices 0x6c0 (address high), 0x6c1 (address low), 0x6c2 (payload) and 0x6c3 (control). Only a write to 0x6c3 starts an operation, and the target address is {high, low}. Writes to any other index change nothing and start nothing.
- R3: A release (control bits [1:0] = 0) with control bit 28 = 1 asserts `mem_valid` in the cycle after the control write. The request carries `mem_wide` = 0, `mem_data[31:0]` equal to the payload and `mem_data[127:32]` equal to zero.
- R4: A release with control bit 28 = 0 issues a request with `mem_wide` = 1. `mem_data[63:0]` holds the zero-extended payload and `mem_data[127:64]` holds the timestamp.
- R5: A counter operation (bits [1:0] = 2) with counter type bits [27:23] = 0 issues a request whose value is zero, in either shape.
- R6: The timestamp is (ns/625)*384 + ((ns mod 625)*384)/625, taken modulo 2^64, where ns is `ns_time` sampled on the control-write edge.
- R7: Acquire (1), trap (3), and a counter operation with a nonzero type each raise `unsupported` for exactly the one cycle after the control write. `busy` and `mem_valid` stay low.
- R8: `busy` is high from the cycle after an accepted control write until the cycle after the handshake (`mem_valid` and `mem_ready` both high). While `mem_ready` is low, the request holds steady.
- R9: While `busy` is high, a control write starts nothing, and payload or address writes do not alter the pending request.
- R10: Control bits other than [1:0], [27:23] and 28 have no effect on the operation or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 12 | Register index of the write |
| wr_data | input | 32 | Register write data |
| ns_time | input | 64 | Free-running nanosecond count |
| busy | output | 1 | An operation is in progress |
| unsupported | output | 1 | One-cycle pulse for a rejected operation |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 128 | Write data, value in low half, timestamp in high half |
| mem_wide | output | 1 | 1 for a 16-byte record, 0 for one 32-bit word |

## Verification
The hardest situation to reach is a control or payload write that arrives while a long-shape operation is still dividing. The divide window is only about 65 cycles, and nothing at the ports shows its progress. The stimulus issues a long release and then, at once, writes a new payload and a different control word. It then checks that the request still carries the first payload and that no second request follows. Timestamps are also driven with random 64-bit nanosecond values, and with values at multiples of 625 and one below them, so that both the quotient path and the remainder path are exercised.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OP_RELEASE = 2'd0,
        OP_ACQUIRE = 2'd1,
        OP_COUNTER = 2'd2,
        OP_TRAP    = 2'd3
    } sem_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_REQ  = 2'd2
    } sem_state_e;

    typedef struct packed {
        sem_op_e    op;
        logic [4:0] ctr_type;
        logic       one_word;
    } sem_ctl_t;

    localparam int CTL_OP_LSB   = 0;
    localparam int CTL_CTR_LSB  = 23;
    localparam int CTL_SIZE_BIT = 28;

    function automatic sem_ctl_t decode_ctl(input logic [31:0] w);
        sem_ctl_t c;
        c.op       = sem_op_e'(w[CTL_OP_LSB +: 2]);
        c.ctr_type = w[CTL_CTR_LSB +: 5];
        c.one_word = w[CTL_SIZE_BIT];
        return c;
    endfunction

    function automatic logic ctl_supported(input sem_ctl_t c);
        return (c.op == OP_RELEASE) || ((c.op == OP_COUNTER) && (c.ctr_type == 5'd0));
    endfunction

endpackage

// File: rtl/sem_divider.sv
module sem_divider #(
    parameter int W   = 64,
    parameter int DIV = 625
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [W-1:0]         dividend,
    output logic                 done,
    output logic [W-1:0]         quotient,
    output logic [$clog2(DIV):0] remainder
);
    localparam int RW = $clog2(DIV) + 1;
    localparam int CW = $clog2(W + 1);
    localparam logic [RW:0] DIVV = (RW + 1)'(DIV);

    logic [CW-1:0] cnt_q;
    logic [RW:0]   trial;
    logic          fits;

    assign trial = {remainder, quotient[W-1]};
    assign fits  = (trial >= DIVV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start) begin
            cnt_q     <= CW'(W);
            done      <= 1'b0;
            quotient  <= dividend;
            remainder <= '0;
        end else if (cnt_q != '0) begin
            cnt_q     <= cnt_q - 1'b1;
            quotient  <= {quotient[W-2:0], fits};
            remainder <= fits ? RW'(trial - DIVV) : trial[RW-1:0];
            if (cnt_q == CW'(1)) done <= 1'b1;
        end
    end
endmodule

// File: rtl/sem_tick_conv.sv
module sem_tick_conv #(
    parameter int NS_W = 64,
    parameter int DIV  = 625,
    parameter int MUL  = 384
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NS_W-1:0] ns_in,
    output logic            done,
    output logic [NS_W-1:0] ticks
);
    localparam int RW = $clog2(DIV) + 1;
    localparam logic [NS_W-1:0] MULV = NS_W'(MUL);
    localparam logic [NS_W-1:0] DIVV = NS_W'(DIV);

    logic [NS_W-1:0] quo;
    logic [RW-1:0]   rem;
    logic [NS_W-1:0] frac;

    sem_divider #(.W(NS_W), .DIV(DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (ns_in),
        .done      (done),
        .quotient  (quo),
        .remainder (rem)
    );

    assign frac  = (NS_W'(rem) * MULV) / DIVV;
    assign ticks = quo * MULV + frac;
endmodule

// File: rtl/sem_release_writer.sv
module sem_release_writer
    import sem_pkg::*;
#(
    parameter int          IDX_W    = 12,
    parameter logic [11:0] BASE_IDX = 12'h6c0,
    parameter int          NS_W     = 64,
    parameter int          TICK_DIV = 625,
    parameter int          TICK_MUL = 384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [NS_W-1:0]  ns_time,
    output logic             busy,
    output logic             unsupported,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [63:0]      mem_addr,
    output logic [127:0]     mem_data,
    output logic             mem_wide
);
    localparam logic [IDX_W-1:0] IDX_HI  = IDX_W'(BASE_IDX);
    localparam logic [IDX_W-1:0] IDX_LO  = IDX_W'(BASE_IDX + 12'd1);
    localparam logic [IDX_W-1:0] IDX_PAY = IDX_W'(BASE_IDX + 12'd2);
    localparam logic [IDX_W-1:0] IDX_CTL = IDX_W'(BASE_IDX + 12'd3);

    sem_state_e  state_q;
    logic [31:0] addr_hi_q, addr_lo_q, payload_q;
    logic [63:0] op_addr_q, op_value_q;
    logic        op_wide_q;
    sem_ctl_t    ctl_d;
    logic        trigger, accept, div_start, div_done;
    logic [NS_W-1:0] ticks;

    assign ctl_d     = decode_ctl(wr_data);
    assign trigger   = wr_en && (wr_idx == IDX_CTL) && (state_q == ST_IDLE);
    assign accept    = trigger && ctl_supported(ctl_d);
    assign div_start = accept && !ctl_d.one_word;

    sem_tick_conv #(.NS_W(NS_W), .DIV(TICK_DIV), .MUL(TICK_MUL)) u_conv (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .ns_in (ns_time),
        .done  (div_done),
        .ticks (ticks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_hi_q   <= '0;
            addr_lo_q   <= '0;
            payload_q   <= '0;
            op_addr_q   <= '0;
            op_value_q  <= '0;
            op_wide_q   <= 1'b0;
            unsupported <= 1'b0;
        end else begin
            unsupported <= trigger && !accept;
            if (wr_en) begin
                if (wr_idx == IDX_HI)  addr_hi_q <= wr_data;
                if (wr_idx == IDX_LO)  addr_lo_q <= wr_data;
                if (wr_idx == IDX_PAY) payload_q <= wr_data;
            end
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_addr_q  <= {addr_hi_q, addr_lo_q};
                    op_value_q <= (ctl_d.op == OP_RELEASE) ? {32'd0, payload_q} : 64'd0;
                    op_wide_q  <= !ctl_d.one_word;
                    state_q    <= ctl_d.one_word ? ST_REQ : ST_DIV;
                end
                ST_DIV:  if (div_done) state_q <= ST_REQ;
                ST_REQ:  if (mem_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign mem_valid = (state_q == ST_REQ);
    assign mem_addr  = op_addr_q;
    assign mem_wide  = op_wide_q;
    assign mem_data  = op_wide_q ? {64'(ticks), op_value_q} : {96'd0, op_value_q[31:0]};
endmodule

// File: rtl/sem_release_writer_chk.sv
module sem_release_writer_chk (
    input logic         clk,
    input logic         rst,
    input logic         busy,
    input logic         unsupported,
    input logic         mem_valid,
    input logic         mem_ready,
    input logic [63:0]  mem_addr,
    input logic [127:0] mem_data,
    input logic         mem_wide
);
    p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_wide)));

    p_drop_after_hs_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (!mem_valid && !busy));

    p_valid_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> (!busy && !mem_valid));

    p_narrow_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_wide) |-> (mem_data[127:32] == 96'd0));
endmodule

bind sem_release_writer sem_release_writer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .unsupported (unsupported),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .mem_wide    (mem_wide)
);

// File: tb/sem_release_writer_tb.sv
module sem_release_writer_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [11:0]  wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic [63:0]  ns_time = '0;
    logic         mem_ready = 1'b0;
    logic         busy, unsupported, mem_valid, mem_wide;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_release_writer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ns_time(ns_time), .busy(busy), .unsupported(unsupported),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_wide(mem_wide)
    );

    function automatic logic [63:0] exp_ts(input logic [63:0] ns);
        return (ns / 64'd625) * 64'd384 + ((ns % 64'd625) * 64'd384) / 64'd625;
    endfunction

    function automatic logic [31:0] mk_ctl(input logic [1:0] op, input logic [4:0] ct,
                                           input logic one, input logic [31:0] junk);
        return (junk & ~32'h1F80_0003) | {3'd0, one, ct, 21'd0, op};
    endfunction

    task automatic check(input logic ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!mem_valid && n < 300) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic finish_req(input string rq);
        int stall;
        logic [127:0] d0;
        logic [63:0] a0;
        stall = $urandom % 4;
        d0 = mem_data; a0 = mem_addr;
        for (int k = 0; k < stall; k++) begin
            @(posedge clk); #1;
            check(mem_valid && mem_data == d0 && mem_addr == a0, "R8", mem_data, d0);
        end
        mem_ready = 1'b1;
        @(posedge clk); #1;
        mem_ready = 1'b0;
        check(!mem_valid && !busy, rq, {mem_valid, busy}, 0);
    endtask

    task automatic run_op(input logic [31:0] hi, lo, pay, ctl, input logic [63:0] ns, input string rq);
        logic sup, one;
        logic [63:0] val;
        logic [127:0] exp;
        int n;
        reg_write(12'h6c0, hi);
        reg_write(12'h6c1, lo);
        reg_write(12'h6c2, pay);
        ns_time = ns;
        reg_write(12'h6c3, ctl);
        sup = (ctl[1:0] == 2'd0) || (ctl[1:0] == 2'd2 && ctl[27:23] == 5'd0);
        one = ctl[28];
        if (!sup) begin
            check(unsupported && !busy && !mem_valid, "R7", {unsupported, busy, mem_valid}, 3'b100);
            @(posedge clk); #1;
            check(!unsupported && !busy && !mem_valid, "R7", {unsupported, busy, mem_valid}, 0);
        end else begin
            check(busy, "R8", busy, 1);
            if (one) check(mem_valid, "R3", mem_valid, 1);
            wait_req(n);
            val = (ctl[1:0] == 2'd0) ? {32'd0, pay} : 64'd0;
            exp = one ? {96'd0, val[31:0]} : {exp_ts(ns), val};
            check(mem_addr == {hi, lo}, "R2", mem_addr, {hi, lo});
            check(mem_wide == !one, one ? "R3" : "R4", mem_wide, !one);
            check(mem_data == exp, rq, mem_data, exp);
            finish_req("R8");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !unsupported && !mem_valid, "R1", {busy, unsupported, mem_valid}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(!busy && !unsupported && !mem_valid, "R1", {busy, unsupported, mem_valid}, 0);

        // directed shapes and ops
        run_op(32'h0000_0001, 32'h2000_0040, 32'hCAFE_F00D, mk_ctl(2'd0, 5'd0, 1'b1, 0), 64'd0, "R3");
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 32'h0BAD_BEEF, mk_ctl(2'd0, 5'd0, 1'b0, 0), 64'd1_000_000_007, "R4");
        run_op(32'h0, 32'h100, 32'hFFFF_FFFF, mk_ctl(2'd2, 5'd0, 1'b1, 0), 64'd5, "R5");
        run_op(32'h0, 32'h200, 32'h1111_2222, mk_ctl(2'd2, 5'd0, 1'b0, 0), 64'd625, "R5");
        run_op(32'h0, 32'h300, 32'h5, mk_ctl(2'd0, 5'd0, 1'b0, 0), 64'd624, "R6");
        run_op(32'h0, 32'h300, 32'h5, mk_ctl(2'd0, 5'd0, 1'b0, 0), 64'd1249, "R6");
        run_op(32'h0, 32'h300, 32'h5, mk_ctl(2'd0, 5'd0, 1'b0, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        run_op(32'h0, 32'h400, 32'h7, mk_ctl(2'd1, 5'd0, 1'b1, 0), 64'd9, "R7");
        run_op(32'h0, 32'h400, 32'h7, mk_ctl(2'd3, 5'd0, 1'b0, 0), 64'd9, "R7");
        run_op(32'h0, 32'h400, 32'h7, mk_ctl(2'd2, 5'd1, 1'b0, 0), 64'd9, "R7");
        run_op(32'hA5A5_0000, 32'h0000_5A5A, 32'h77, mk_ctl(2'd0, 5'd0, 1'b1, 32'hE07F_FFFC), 64'd3, "R10");

        // R2: stray indices change nothing and start nothing
        reg_write(12'h6c0, 32'h0000_00AA);
        reg_write(12'h6c1, 32'h0000_00BB);
        reg_write(12'h6c2, 32'h0000_00CC);
        reg_write(12'h6bf, 32'hDEAD_0001);
        reg_write(12'h6c4, mk_ctl(2'd0, 5'd0, 1'b1, 0));
        check(!busy && !mem_valid && !unsupported, "R2", {busy, mem_valid, unsupported}, 0);
        reg_write(12'h6c3, mk_ctl(2'd0, 5'd0, 1'b1, 0));
        check(mem_valid && mem_addr == 64'h0000_00AA_0000_00BB && mem_data == 128'hCC, "R2",
              {mem_addr, mem_data[63:0]}, {64'h0000_00AA_0000_00BB, 64'hCC});
        finish_req("R8");

        // R9: writes while a long operation is dividing
        reg_write(12'h6c0, 32'h0000_0011);
        reg_write(12'h6c1, 32'h0000_2200);
        reg_write(12'h6c2, 32'h1357_9BDF);
        ns_time = 64'd987_654_321;
        reg_write(12'h6c3, mk_ctl(2'd0, 5'd0, 1'b0, 0));
        reg_write(12'h6c2, 32'h0F0F_0F0F);
        reg_write(12'h6c1, 32'h0000_9900);
        reg_write(12'h6c3, mk_ctl(2'd0, 5'd0, 1'b1, 0));
        check(busy && !unsupported, "R9", {busy, unsupported}, 2'b10);
        wait_req(n);
        check(mem_wide && mem_addr == 64'h0000_0011_0000_2200, "R9", mem_addr, 64'h0000_0011_0000_2200);
        check(mem_data == {exp_ts(64'd987_654_321), 64'h1357_9BDF}, "R9",
              mem_data, {exp_ts(64'd987_654_321), 64'h1357_9BDF});
        finish_req("R8");
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            check(!mem_valid && !busy, "R9", {mem_valid, busy}, 0);
        end

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0] op;
            logic [4:0] ct;
            logic [63:0] ns;
            op = 2'($urandom % 4);
            if (i % 3 == 0) op = 2'd0;
            ct = ($urandom % 2) ? 5'd0 : 5'($urandom);
            ns = {32'($urandom), 32'($urandom)};
            run_op($urandom, $urandom, $urandom, mk_ctl(op, ct, 1'($urandom), $urandom), ns,
                   (op == 2'd2) ? "R5" : "R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule